// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block manages the two low-power states of a small 8-bit microcontroller. It holds one power-control register on the special-function-register bus. It drives two clock enables, one for the CPU clock domain and one for the peripheral clock domain. Software enters idle by setting the idle bit. Idle stops only the CPU clock, so the timers and the interrupt logic keep running. Software enters power-down by setting the power-down bit, which stops both clocks.

Idle ends on any enabled interrupt, which the interrupt controller reports as a single request line. A software-selected idle type decides what happens at that point. The core either takes the interrupt vector normally, or it resumes where it stopped. In the second case a one-cycle suppress pulse tells the interrupt controller to leave the request pending.

Power-down ends only on a level from one of four external interrupt lines or from the ring-detect line. These wake lines are resynchronised through two flops on the free-running reference clock before the clocks are released. On either wake-up, the hardware clears the mode bit that was set.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, both clock enables are 1 and the suppress output is 0.
- R2: The register decodes at address 0x87. Bit 0 is the idle request, bit 1 is the power-down request, bits 2 and 3 are software flags and bit 4 is the idle type (1 = resume without vectoring). Bits 7 to 5 read 0, and any other address reads 0x00.
- R3: A write that sets bit 0 alone clears the CPU clock enable from the next cycle on, while the peripheral clock enable stays 1.
- R4: A write that sets bit 1 clears both clock enables from the next cycle on.
- R5: A write with bits 0 and 1 both set enters power-down only: the register then reads bit 1 set and bit 0 clear.
- R6: In idle, the interrupt request seen at a clock edge clears bit 0 at that edge, and the CPU clock enable is 1 in the following cycle.
- R7: An idle wake with bit 4 set raises the suppress output for exactly one cycle. With bit 4 clear, the suppress output stays 0.
- R8: In power-down, the interrupt request line has no effect. Only the external lines (any of 4) or the ring-detect line, all active high, end power-down.
- R9: A wake level first sampled at edge A clears bit 1 at edge A+2, so both clock enables are 1 from the cycle after that edge.
- R10: The flag bits read back as last written and never change either clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (combinational) |
| irq_req | input | 1 | Any enabled interrupt pending, from the interrupt controller |
| ext_irq | input | 4 | External interrupt lines, active high |
| ring_det | input | 1 | Ring-detect wake line, active high |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| vec_suppress | output | 1 | One-cycle pulse: resume from idle without vectoring |

## Verification
The bench drives inputs on the falling edge and samples on the falling edge. A register write or an idle wake becomes visible in the clock enables one half-cycle later, after the rising edge that samples it. A power-down wake level passes two synchroniser flops and the mode register, so the bench checks that the enables are still 0 after the first and second rising edges and are 1 after the third. The suppress pulse is checked in the cycle after the wake edge, and checked again one cycle later to confirm that it has dropped.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter logic [7:0] REG_ADDR = 8'h87,
  parameter int N_EXT = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_we,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       irq_req,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic       ring_det,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       vec_suppress
);
  logic idl, pd, idle_type;
  logic [1:0] flags;
  logic [SYNC_LEN-1:0] wake_sync;

  wire hit       = sfr_addr == REG_ADDR;
  wire wake_lvl  = |ext_irq | ring_det;
  wire pd_wake   = pd & wake_sync[SYNC_LEN-1];
  wire idle_wake = idl & ~pd & irq_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wake_sync <= '0;
    else        wake_sync <= {wake_sync[SYNC_LEN-2:0], wake_lvl};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idl <= 1'b0; pd <= 1'b0; idle_type <= 1'b0; flags <= 2'b0;
      vec_suppress <= 1'b0;
    end else begin
      vec_suppress <= idle_wake & idle_type;
      if (pd_wake) begin
        pd  <= 1'b0;
        idl <= 1'b0;
      end else if (idle_wake) begin
        idl <= 1'b0;
      end else if (sfr_we && hit) begin
        pd        <= sfr_wdata[1];
        idl       <= sfr_wdata[0] & ~sfr_wdata[1];
        flags     <= sfr_wdata[3:2];
        idle_type <= sfr_wdata[4];
      end
    end

  assign cpu_clk_en = ~(idl | pd);
  assign per_clk_en = ~pd;
  assign sfr_rdata  = hit ? {3'b000, idle_type, flags, pd, idl} : 8'h00;
endmodule

module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sfr_rdata,
  input logic       irq_req,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       vec_suppress
);
  AST_PD_STOPS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |-> !cpu_clk_en); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata[7:5] == 3'b000); // R2
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && irq_req) |=> cpu_clk_en); // R6
  AST_SUPPRESS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_suppress |=> !vec_suppress); // R7
  AST_SUPPRESS_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_suppress |-> $past(!cpu_clk_en && per_clk_en)); // R7
  AST_PD_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_clk_en && $past(!per_clk_en)) |-> !vec_suppress); // R8
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_rdata(sfr_rdata), .irq_req(irq_req),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .vec_suppress(vec_suppress)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 6;
  // {write data, expected readback, expected cpu_clk_en, expected per_clk_en}
  localparam logic [17:0] VECS [N_VEC] = '{
    {8'hFC, 8'h1C, 1'b1, 1'b1},
    {8'h04, 8'h04, 1'b1, 1'b1},
    {8'h08, 8'h08, 1'b1, 1'b1},
    {8'h10, 8'h10, 1'b1, 1'b1},
    {8'hE0, 8'h00, 1'b1, 1'b1},
    {8'h0C, 8'h0C, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h87, sfr_wdata = 8'h00;
  logic sfr_we = 1'b0, irq_req = 1'b0, ring_det = 1'b0;
  logic [3:0] ext_irq = 4'h0;
  logic [7:0] sfr_rdata;
  logic cpu_clk_en, per_clk_en, vec_suppress;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl u_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_req(irq_req),
    .ext_irq(ext_irq), .ring_det(ring_det), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .vec_suppress(vec_suppress)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [7:0] rd, input logic c,
                           input logic p, input logic s);
    chk({req, " rdata"}, sfr_rdata, rd);
    chk({req, " cpu_clk_en"}, {7'b0, cpu_clk_en}, {7'b0, c});
    chk({req, " per_clk_en"}, {7'b0, per_clk_en}, {7'b0, p});
    chk({req, " vec_suppress"}, {7'b0, vec_suppress}, {7'b0, s});
  endtask

  task automatic wr(input logic [7:0] d);
    sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 reset", 8'h00, 1, 1, 0);

    for (int i = 0; i < N_VEC; i++) begin
      wr(VECS[i][17:10]);
      chk_state("R2/R10 table", VECS[i][9:2], VECS[i][1], VECS[i][0], 0);
    end
    sfr_addr = 8'h88;
    #1 chk("R2 other address", sfr_rdata, 8'h00);
    sfr_addr = 8'h87;

    // R3 + R6 + R7: idle with idle type 1
    wr(8'h11);
    chk_state("R3 idle entry", 8'h11, 0, 1, 0);
    idle_cycles(3);
    chk_state("R3 idle held", 8'h11, 0, 1, 0);
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
    chk_state("R6 R7 idle wake type1", 8'h10, 1, 1, 1);
    @(negedge clk);
    chk_state("R7 suppress one cycle", 8'h10, 1, 1, 0);

    // R7: idle type 0, no suppress
    wr(8'h01);
    chk_state("R3 idle type0 entry", 8'h01, 0, 1, 0);
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
    chk_state("R6 R7 idle wake type0", 8'h00, 1, 1, 0);

    // R4 + R8 + R9: power-down, external wake
    wr(8'h1A);
    chk_state("R4 pd entry", 8'h1A, 0, 0, 0);
    irq_req = 1'b1; idle_cycles(4); irq_req = 1'b0;
    chk_state("R8 irq ignored in pd", 8'h1A, 0, 0, 0);
    ext_irq = 4'b0100;
    @(negedge clk);
    chk_state("R9 after first sync edge", 8'h1A, 0, 0, 0);
    @(negedge clk);
    chk_state("R9 after second sync edge", 8'h1A, 0, 0, 0);
    @(negedge clk);
    chk_state("R9 R8 ext wake", 8'h18, 1, 1, 0);
    ext_irq = 4'h0;
    idle_cycles(4);

    // R5: both bits, ring-detect wake
    wr(8'h03);
    chk_state("R5 pd priority", 8'h02, 0, 0, 0);
    ring_det = 1'b1;
    idle_cycles(2);
    chk_state("R9 ring not yet", 8'h02, 0, 0, 0);
    @(negedge clk);
    chk_state("R8 ring wake", 8'h00, 1, 1, 0);
    ring_det = 1'b0;
    idle_cycles(4);

    // R8: highest external line
    wr(8'h02);
    ext_irq = 4'b1000;
    idle_cycles(3);
    chk_state("R8 ext3 wake", 8'h00, 1, 1, 0);
    ext_irq = 4'h0;
    idle_cycles(3);

    // R1: reset in the middle of power-down
    wr(8'h1E);
    rst_n = 1'b0; #1;
    chk_state("R1 async reset", 8'h00, 1, 1, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule